// File: doc/BRIEF.md
# Radix Translation Context Selector

This block sits at the front of a two-level radix address translator. For every request it looks at a 64-bit effective address together with the current privilege level (hypervisor or guest) and the relocation setting. From these it decides which partition identifier and which process identifier the later table walk should use. If the address cannot be translated in the current context, it reports a segment fault instead.

When relocation is off in hypervisor mode, no translation is done at all. The block forms the real address directly and grants full access.

A request strobe captures the inputs. One clock later the block returns the result together with a one-cycle done pulse. The result stays unchanged until the next strobe. Page-table walking and permission checking belong to the stages that consume this output.

Top module: `radix_ctx_decoder`

## Requirements
- R1: `done_o` pulses high for exactly one cycle on the clock edge after the edge that samples `req_i` high. All result outputs change only on that edge and stay stable while no request arrives.
- R2: On a translated request (every case except hypervisor with relocation off), any nonzero bit in the reserved field `ea_i[61:52]` produces a segment fault.
- R3: In hypervisor mode with a legal address, the quadrant `ea_i[63:62]` selects the identifiers as follows:
  - 0: partition 0 and the PID register
  - 1: both registers
  - 2: the LPID register and process 0
  - 3: both identifiers 0
- R4: In guest mode with a legal address, the identifiers are chosen as follows:
  - quadrant 0: both registers
  - quadrant 3: the LPID register and process 0
- R5: In guest mode, quadrants 1 and 2 produce a segment fault.
- R6: The access encoding on `acc_i` is 0 fetch, 1 load, 2 store, and 3 is handled as a load. On a segment fault:
  - `fault_o` is 1 and `valid_o` is 0.
  - `lpid_o` and `pid_o` are 0.
  - `fault_class_o` is 1 (instruction segment) with `fault_addr_o` 0 for a fetch.
  - `fault_class_o` is 2 (data segment) with `fault_addr_o` equal to the effective address for a load or store.
  - Without a fault, `fault_class_o` is 0.
- R7: In hypervisor mode with relocation off:
  - `bypass_o` and `valid_o` are 1.
  - `real_addr_o` is the effective address with bits [63:60] cleared.
  - The quadrant and reserved bits are ignored.
  - On every other request, `real_addr_o` is 0.
- R8: On the bypass path, the offset register is ORed into the real address only when `ea_i[63]` is 0.
- R9: `perm_o` ({read, write, execute}) is 3'b111 on the bypass path and 3'b000 otherwise.
- R10: After reset, every output is 0.
- R11: In guest mode with relocation off, the request is decoded exactly like a translated guest request, with no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, samples all inputs |
| ea_i | input | 64 | Effective address |
| hv_i | input | 1 | Hypervisor privilege |
| reloc_i | input | 1 | Relocation enable |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lpid_reg_i | input | 12 | Partition identifier register |
| pid_reg_i | input | 20 | Process identifier register |
| rmo_reg_i | input | 64 | Real-mode offset register |
| done_o | output | 1 | Result-ready pulse |
| valid_o | output | 1 | Context selected or bypass done |
| bypass_o | output | 1 | Real-mode bypass taken |
| lpid_o | output | 12 | Selected partition identifier |
| pid_o | output | 20 | Selected process identifier |
| real_addr_o | output | 64 | Bypass real address |
| perm_o | output | 3 | Granted read/write/execute |
| fault_o | output | 1 | Segment fault |
| fault_class_o | output | 2 | 1 instruction segment, 2 data segment |
| fault_addr_o | output | 64 | Faulting address for data accesses |

## Verification
The hardest situations to reach are those where two fault sources or two paths overlap. One is a hypervisor request with relocation off whose reserved bits and quadrant would fault on the translated path; these must be ignored. Another is a guest request with relocation off, which must not take the bypass. The stimulus sets the reserved bits deliberately on bypass requests and replays illegal quadrants with relocation cleared. The offset register stays nonzero for the whole table run, so any leak of it into translated results shows up.

// File: rtl/radix_ctx_pkg.sv
package radix_ctx_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FC_NONE     = 2'd0,
      FC_INSN_SEG = 2'd1,
      FC_DATA_SEG = 2'd2
   } fclass_e;

   typedef struct packed {
      logic legal;
      logic lpid_from_reg;
      logic pid_from_reg;
   } qsel_t;

   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/radix_quad_map.sv
module radix_quad_map
   import radix_ctx_pkg::*;
#(
   parameter int QUAD_W = 2
) (
   input  logic [QUAD_W-1:0] quad_i,
   input  logic              hv_i,
   output qsel_t             sel_o
);
   generate
      if (QUAD_W != 2) begin : g_bad_w
         $error("radix_quad_map: QUAD_W must be 2");
      end
   endgenerate

   always_comb begin
      sel_o = '{legal: 1'b0, lpid_from_reg: 1'b0, pid_from_reg: 1'b0};
      unique case ({hv_i, quad_i})
         3'b1_00: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b0, pid_from_reg: 1'b1};
         3'b1_01: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b1, pid_from_reg: 1'b1};
         3'b1_10: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b1, pid_from_reg: 1'b0};
         3'b1_11: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b0, pid_from_reg: 1'b0};
         3'b0_00: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b1, pid_from_reg: 1'b1};
         3'b0_11: sel_o = '{legal: 1'b1, lpid_from_reg: 1'b1, pid_from_reg: 1'b0};
         default: sel_o = '{legal: 1'b0, lpid_from_reg: 1'b0, pid_from_reg: 1'b0};
      endcase
   end
endmodule

// File: rtl/radix_seg_check.sv
module radix_seg_check #(
   parameter int EA_W   = 64,
   parameter int RSV_LO = 52,
   parameter int RSV_W  = 10
) (
   input  logic [EA_W-1:0] ea_i,
   output logic            rsv_bad_o
);
   generate
      if (RSV_LO + RSV_W > EA_W) begin : g_bad_range
         $error("radix_seg_check: reserved field exceeds address width");
      end
      if (RSV_W > 0) begin : g_check
         assign rsv_bad_o = |ea_i[RSV_LO +: RSV_W];
      end else begin : g_nocheck
         assign rsv_bad_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/radix_realmode.sv
module radix_realmode #(
   parameter int EA_W   = 64,
   parameter int CLR_W  = 4,
   parameter bit RMO_EN = 1'b1
) (
   input  logic [EA_W-1:0] ea_i,
   input  logic [EA_W-1:0] rmo_i,
   output logic [EA_W-1:0] raddr_o
);
   localparam int KEEP_W = EA_W - CLR_W;

   logic [EA_W-1:0] masked;

   generate
      if (CLR_W <= 0 || CLR_W >= EA_W) begin : g_bad_clr
         $error("radix_realmode: CLR_W out of range");
      end
   endgenerate

   assign masked = {{CLR_W{1'b0}}, ea_i[KEEP_W-1:0]};

   generate
      if (RMO_EN) begin : g_rmo
         assign raddr_o = ea_i[EA_W-1] ? masked : (masked | rmo_i);
      end else begin : g_normo
         assign raddr_o = masked;
      end
   endgenerate
endmodule

// File: rtl/radix_fault_class.sv
module radix_fault_class
   import radix_ctx_pkg::*;
#(
   parameter int EA_W = 64
) (
   input  logic [1:0]      acc_i,
   input  logic [EA_W-1:0] ea_i,
   output logic [1:0]      class_o,
   output logic [EA_W-1:0] addr_o
);
   always_comb begin
      if (acc_e'(acc_i) == ACC_FETCH) begin
         class_o = FC_INSN_SEG;
         addr_o  = '0;
      end else begin
         class_o = FC_DATA_SEG;
         addr_o  = ea_i;
      end
   end
endmodule

// File: rtl/radix_ctx_decoder.sv
module radix_ctx_decoder
   import radix_ctx_pkg::*;
#(
   parameter int EA_W   = 64,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20,
   parameter int QUAD_W = 2,
   parameter int RSV_W  = 10,
   parameter int CLR_W  = 4,
   parameter bit RMO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [EA_W-1:0]   ea_i,
   input  logic              hv_i,
   input  logic              reloc_i,
   input  logic [1:0]        acc_i,
   input  logic [LPID_W-1:0] lpid_reg_i,
   input  logic [PID_W-1:0]  pid_reg_i,
   input  logic [EA_W-1:0]   rmo_reg_i,
   output logic              done_o,
   output logic              valid_o,
   output logic              bypass_o,
   output logic [LPID_W-1:0] lpid_o,
   output logic [PID_W-1:0]  pid_o,
   output logic [EA_W-1:0]   real_addr_o,
   output logic [2:0]        perm_o,
   output logic              fault_o,
   output logic [1:0]        fault_class_o,
   output logic [EA_W-1:0]   fault_addr_o
);
   localparam int QUAD_LO = EA_W - QUAD_W;
   localparam int RSV_LO  = QUAD_LO - RSV_W;

   generate
      if (RSV_LO < 0) begin : g_bad_layout
         $error("radix_ctx_decoder: quadrant and reserved fields exceed EA_W");
      end
   endgenerate

   qsel_t            qsel;
   logic             rsv_bad;
   logic [EA_W-1:0]  rm_addr;
   logic [1:0]       fc_raw;
   logic [EA_W-1:0]  fa_raw;

   radix_quad_map #(.QUAD_W(QUAD_W)) u_quad (
      .quad_i (ea_i[EA_W-1:QUAD_LO]),
      .hv_i   (hv_i),
      .sel_o  (qsel)
   );

   radix_seg_check #(.EA_W(EA_W), .RSV_LO(RSV_LO), .RSV_W(RSV_W)) u_seg (
      .ea_i      (ea_i),
      .rsv_bad_o (rsv_bad)
   );

   radix_realmode #(.EA_W(EA_W), .CLR_W(CLR_W), .RMO_EN(RMO_EN)) u_rm (
      .ea_i    (ea_i),
      .rmo_i   (rmo_reg_i),
      .raddr_o (rm_addr)
   );

   radix_fault_class #(.EA_W(EA_W)) u_fc (
      .acc_i   (acc_i),
      .ea_i    (ea_i),
      .class_o (fc_raw),
      .addr_o  (fa_raw)
   );

   logic              bypass_n, fault_n, valid_n;
   logic [LPID_W-1:0] lpid_n;
   logic [PID_W-1:0]  pid_n;
   logic [EA_W-1:0]   real_n, faddr_n;
   logic [2:0]        perm_n;
   logic [1:0]        fclass_n;

   always_comb begin
      bypass_n = hv_i & ~reloc_i;
      fault_n  = ~bypass_n & (rsv_bad | ~qsel.legal);
      valid_n  = ~fault_n;
      lpid_n   = (!bypass_n && !fault_n && qsel.lpid_from_reg) ? lpid_reg_i : '0;
      pid_n    = (!bypass_n && !fault_n && qsel.pid_from_reg)  ? pid_reg_i  : '0;
      real_n   = bypass_n ? rm_addr : '0;
      perm_n   = bypass_n ? PERM_ALL : PERM_NONE;
      fclass_n = fault_n ? fc_raw : FC_NONE;
      faddr_n  = fault_n ? fa_raw : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o        <= 1'b0;
         valid_o       <= 1'b0;
         bypass_o      <= 1'b0;
         lpid_o        <= '0;
         pid_o         <= '0;
         real_addr_o   <= '0;
         perm_o        <= '0;
         fault_o       <= 1'b0;
         fault_class_o <= '0;
         fault_addr_o  <= '0;
      end else begin
         done_o <= req_i;
         if (req_i) begin
            valid_o       <= valid_n;
            bypass_o      <= bypass_n;
            lpid_o        <= lpid_n;
            pid_o         <= pid_n;
            real_addr_o   <= real_n;
            perm_o        <= perm_n;
            fault_o       <= fault_n;
            fault_class_o <= fclass_n;
            fault_addr_o  <= faddr_n;
         end
      end
   end
endmodule

// File: rtl/radix_ctx_decoder_chk.sv
module radix_ctx_decoder_chk #(
   parameter int EA_W   = 64,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20,
   parameter int QUAD_W = 2,
   parameter int RSV_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [EA_W-1:0]   ea_i,
   input logic              hv_i,
   input logic              reloc_i,
   input logic              done_o,
   input logic              valid_o,
   input logic              bypass_o,
   input logic [LPID_W-1:0] lpid_o,
   input logic [PID_W-1:0]  pid_o,
   input logic [EA_W-1:0]   real_addr_o,
   input logic [2:0]        perm_o,
   input logic              fault_o,
   input logic [1:0]        fault_class_o,
   input logic [EA_W-1:0]   fault_addr_o
);
   localparam int RSV_LO = EA_W - QUAD_W - RSV_W;

   logic rsv_nz;
   logic quad_mixed;
   assign rsv_nz     = |ea_i[RSV_LO +: RSV_W];
   assign quad_mixed = ea_i[EA_W-1] ^ ea_i[EA_W-2];

   p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> done_o);
   p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !done_o);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(lpid_o) && $stable(pid_o) && $stable(real_addr_o)
                  && $stable(fault_o) && $stable(valid_o)));
   p_rsv_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !(hv_i && !reloc_i) && rsv_nz) |=> fault_o);
   p_hv_q3_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && hv_i && reloc_i && ea_i[EA_W-1] && ea_i[EA_W-2] && !rsv_nz)
      |=> (valid_o && lpid_o == '0 && pid_o == '0));
   p_guest_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !hv_i && quad_mixed) |=> (fault_o && !valid_o));
   p_fault_ids_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (lpid_o == '0 && pid_o == '0 && fault_class_o != 2'd0));
   p_fetch_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && fault_class_o == 2'd1) |-> fault_addr_o == '0);
   p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && hv_i && !reloc_i) |=> (bypass_o && valid_o && !fault_o));
   p_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_o != 3'b000) |-> (bypass_o && perm_o == 3'b111));
endmodule

bind radix_ctx_decoder radix_ctx_decoder_chk #(
   .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .QUAD_W(QUAD_W), .RSV_W(RSV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .ea_i(ea_i), .hv_i(hv_i),
   .reloc_i(reloc_i), .done_o(done_o), .valid_o(valid_o), .bypass_o(bypass_o),
   .lpid_o(lpid_o), .pid_o(pid_o), .real_addr_o(real_addr_o), .perm_o(perm_o),
   .fault_o(fault_o), .fault_class_o(fault_class_o), .fault_addr_o(fault_addr_o)
);

// File: tb/tb_radix_ctx_decoder.sv
`timescale 1ns/1ps
module tb_radix_ctx_decoder;
   localparam logic [11:0] LPID_V = 12'hA5C;
   localparam logic [19:0] PID_V  = 20'h31234;
   localparam logic [63:0] RMO_V  = 64'h0000_0001_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [63:0] ea_i = '0;
   logic        hv_i = 1'b0, reloc_i = 1'b0;
   logic [1:0]  acc_i = '0;
   logic [11:0] lpid_reg_i = LPID_V;
   logic [19:0] pid_reg_i = PID_V;
   logic [63:0] rmo_reg_i = RMO_V;
   logic        done_o, valid_o, bypass_o, fault_o;
   logic [11:0] lpid_o;
   logic [19:0] pid_o;
   logic [63:0] real_addr_o, fault_addr_o;
   logic [2:0]  perm_o;
   logic [1:0]  fault_class_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   radix_ctx_decoder dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ea_i(ea_i), .hv_i(hv_i),
      .reloc_i(reloc_i), .acc_i(acc_i), .lpid_reg_i(lpid_reg_i),
      .pid_reg_i(pid_reg_i), .rmo_reg_i(rmo_reg_i), .done_o(done_o),
      .valid_o(valid_o), .bypass_o(bypass_o), .lpid_o(lpid_o), .pid_o(pid_o),
      .real_addr_o(real_addr_o), .perm_o(perm_o), .fault_o(fault_o),
      .fault_class_o(fault_class_o), .fault_addr_o(fault_addr_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic hv, input logic rl, input logic [1:0] acc,
                        input logic [63:0] ea);
      @(negedge clk);
      hv_i = hv; reloc_i = rl; acc_i = acc; ea_i = ea; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
   endtask

   // {hv, reloc, acc, ea, exp_valid, exp_fault, lpid_from_reg, pid_from_reg}
   localparam int NV = 12;
   localparam logic [71:0] VEC [NV] = '{
      {1'b1,1'b1,2'd1,64'h0000_0000_0000_1000,1'b1,1'b0,1'b0,1'b1},
      {1'b1,1'b1,2'd2,64'h4000_0000_0000_2000,1'b1,1'b0,1'b1,1'b1},
      {1'b1,1'b1,2'd0,64'h8000_0000_0000_3000,1'b1,1'b0,1'b1,1'b0},
      {1'b1,1'b1,2'd1,64'hC000_0000_0000_4000,1'b1,1'b0,1'b0,1'b0},
      {1'b0,1'b1,2'd1,64'h0000_0000_0000_5000,1'b1,1'b0,1'b1,1'b1},
      {1'b0,1'b1,2'd2,64'h4000_0000_0000_6000,1'b0,1'b1,1'b0,1'b0},
      {1'b0,1'b1,2'd0,64'h8000_0000_0000_7000,1'b0,1'b1,1'b0,1'b0},
      {1'b0,1'b1,2'd0,64'hC000_0000_0000_8000,1'b1,1'b0,1'b1,1'b0},
      {1'b1,1'b1,2'd1,64'h0010_0000_0000_9000,1'b0,1'b1,1'b0,1'b0},
      {1'b0,1'b1,2'd0,64'hE000_0000_0000_A000,1'b0,1'b1,1'b0,1'b0},
      {1'b0,1'b0,2'd1,64'h0000_0000_0000_B000,1'b1,1'b0,1'b1,1'b1},
      {1'b0,1'b0,2'd3,64'h4000_0000_0000_C000,1'b0,1'b1,1'b0,1'b0}
   };

   initial begin
      // R10: reset values
      #1;
      chk("R10 done", 64'(done_o), 0);
      chk("R10 valid", 64'(valid_o), 0);
      chk("R10 fault", 64'(fault_o), 0);
      chk("R10 perm", 64'(perm_o), 0);
      chk("R10 real", real_addr_o, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [71:0] v;
         logic [63:0] ea;
         logic [1:0]  acc;
         string tag;
         v   = VEC[i];
         ea  = v[67:4];
         acc = v[69:68];
         issue(v[71], v[70], acc, ea);
         if (!v[71] && !v[70])  tag = "R11";
         else if (v[2] && |ea[61:52]) tag = "R2";
         else if (v[2])         tag = "R5";
         else if (v[71])        tag = "R3";
         else                   tag = "R4";
         chk({"R1 done ", tag}, 64'(done_o), 1);
         chk({tag, " valid"}, 64'(valid_o), 64'(v[3]));
         chk({tag, " fault"}, 64'(fault_o), 64'(v[2]));
         chk({tag, " lpid"}, 64'(lpid_o), v[1] ? 64'(LPID_V) : 0);
         chk({tag, " pid"}, 64'(pid_o), v[0] ? 64'(PID_V) : 0);
         chk("R7 no bypass", 64'(bypass_o), 0);
         chk("R7 real zero", real_addr_o, 0);
         chk("R9 perm none", 64'(perm_o), 0);
         if (v[2]) begin
            chk("R6 class", 64'(fault_class_o), (acc == 2'd0) ? 1 : 2);
            chk("R6 addr", fault_addr_o, (acc == 2'd0) ? 64'd0 : ea);
         end else begin
            chk("R6 class none", 64'(fault_class_o), 0);
         end
      end

      // R1: outputs hold without a request, done drops
      @(negedge clk);
      chk("R1 done drop", 64'(done_o), 0);
      hv_i = 1'b1; reloc_i = 1'b0; ea_i = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R1 hold fault", 64'(fault_o), 1);
      chk("R1 hold bypass", 64'(bypass_o), 0);

      // R7 R8: bypass with reserved/quadrant bits set, top bit clear -> offset ORed
      issue(1'b1, 1'b0, 2'd1, 64'h3456_0000_0000_ABCD);
      chk("R7 bypass", 64'(bypass_o), 1);
      chk("R7 valid", 64'(valid_o), 1);
      chk("R7 no fault", 64'(fault_o), 0);
      chk("R8 real rmo", real_addr_o, 64'h0456_0001_0000_ABCD);
      chk("R9 perm all", 64'(perm_o), 3'b111);
      chk("R7 ids zero", 64'({lpid_o, pid_o}), 0);

      // R8: top bit set -> offset not applied
      issue(1'b1, 1'b0, 2'd0, 64'hF123_0000_0000_0010);
      chk("R8 real no rmo", real_addr_o, 64'h0123_0000_0000_0010);
      chk("R9 perm all fetch", 64'(perm_o), 3'b111);

      // R2 with store: reserved bit 61 set in hv quadrant 0
      issue(1'b1, 1'b1, 2'd2, 64'h2000_0000_0000_0040);
      chk("R2 fault", 64'(fault_o), 1);
      chk("R6 data addr", fault_addr_o, 64'h2000_0000_0000_0040);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule